// File: doc/BRIEF.md
# Interrupt State Save and Restore Sequencer

This block runs the exception entry and exit sequences of an 8-bit processor core. A software trap, a hardware interrupt or a mask-and-wait instruction starts an entry sequence. The sequencer copies the live register file onto the system stack, one byte per clock, through a byte-wide memory port. It then reads a 16-bit big-endian handler address from a fixed vector slot. In the same cycle it loads the program counter, the updated condition codes and the new stack pointer. A return request runs the reverse walk: it pulls the condition codes first, and their E bit (bit 7) decides whether the whole frame or only the return address follows.

The core's decoder raises one request line per event. A software trap carries a 2-bit selector for its three flavours. The sequencer reads the register file directly and writes it back through dedicated load strobes for PC, CC and S, plus a byte-lane port for the other registers. `busy` covers the whole sequence. `done` pulses in its final cycle.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset, `busy`, `done`, `memWr`, `memRd`, `pcLoad`, `ccLoad`, `sLoad` and `laneWe` are all 0.
- R2: A full-state entry (SWI, SWI2, SWI3, IRQ, NMI, mask-and-wait) writes 12 bytes, one per cycle. Each write goes to S-1 and then S is decremented. The write order is PC low, PC high, U low, U high, Y low, Y high, X low, X high, DP, B, A, CC. The stacked CC has bit 7 (E) set.
- R3: An FIRQ entry stacks CC with E cleared and writes only PC low, PC high and CC, so the whole sequence is 5 busy cycles.
- R4: After stacking, the sequencer reads the vector high byte at the slot address and the low byte at the slot address + 1. Slot addresses are: SWI3 0xFFF2, SWI2 0xFFF4, FIRQ 0xFFF6, IRQ 0xFFF8, SWI 0xFFFA, NMI 0xFFFC. A full entry is 14 busy cycles.
- R5: The CC loaded at the end of an entry is the stacked CC with extra bits set. SWI sets I (bit 4) and F (bit 6). SWI2 and SWI3 set nothing. IRQ sets I. FIRQ and NMI set I and F.
- R6: In the last cycle of every sequence, `done` pulses, `sLoad` writes the final stack pointer and `pcLoad` writes the new PC. `busy` falls on the next cycle.
- R7: The mask-and-wait request ANDs CC with `cwaiMask`, sets E and stacks the full frame. It then holds `busy` with no memory traffic until an NMI, or an IRQ or FIRQ that the masked CC leaves enabled, arrives. It then vectors for that interrupt.
- R8: A return pulls CC at S first. If the pulled E is 1, it then pulls A, B, DP, X high, X low, Y high, Y low, U high, U low, PC high, PC low (12 cycles). If E is 0, it pulls PC high and PC low only (3 cycles). S increments once per byte. Lane codes on `laneSel` are U low 2, U high 3, Y low 4, Y high 5, X low 6, X high 7, DP 8, B 9, A 10.
- R9: Requests present together in an idle cycle are served in the order NMI, FIRQ, IRQ, software trap, mask-and-wait, return.
- R10: IRQ is not accepted while CC bit 4 is 1, and FIRQ is not accepted while CC bit 6 is 1. NMI cannot be masked.
- R11: Every request that arrives while a sequence is running is ignored, except the wake-up interrupt in the wait phase of R7.
- R12: A software trap with `swiSel` 0 is SWI, 1 is SWI2 and 2 is SWI3. A selector of 3 is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiReq | input | 1 | Non-maskable interrupt request |
| firqReq | input | 1 | Fast interrupt request |
| irqReq | input | 1 | Normal interrupt request |
| swiReq | input | 1 | Software trap request |
| swiSel | input | 2 | Software trap flavour |
| cwaiReq | input | 1 | Mask-and-wait request |
| cwaiMask | input | 8 | AND mask applied to CC for mask-and-wait |
| rtiReq | input | 1 | Return-from-interrupt request |
| pcIn | input | 16 | Current PC (return address) |
| uIn | input | 16 | Current U |
| yIn | input | 16 | Current Y |
| xIn | input | 16 | Current X |
| sIn | input | 16 | Current system stack pointer |
| dpIn | input | 8 | Current DP |
| aIn | input | 8 | Current A |
| bIn | input | 8 | Current B |
| ccIn | input | 8 | Current CC |
| memAddr | output | 16 | Memory address |
| memWr | output | 1 | Memory write strobe |
| memRd | output | 1 | Memory read strobe (data returned in the same cycle) |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data |
| pcLoad | output | 1 | Load PC from pcOut |
| pcOut | output | 16 | New PC |
| ccLoad | output | 1 | Load CC from ccOut |
| ccOut | output | 8 | New CC |
| sLoad | output | 1 | Load S from sOut |
| sOut | output | 16 | New S |
| laneWe | output | 1 | Byte-lane register load strobe |
| laneSel | output | 4 | Byte-lane code (R8) |
| laneData | output | 8 | Byte-lane data |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last cycle of a sequence |

## Verification
Two kinds of event can meet in one cycle. One is a hardware interrupt arriving in the same idle cycle as a software trap or another interrupt. The other is an interrupt arriving while a stacking or return walk is already running. The bench provokes the first by raising several request lines in one idle cycle. It judges the result by which vector ends up in PC and by the length of the busy window. It provokes the second by pulsing NMI and return requests in the middle of a trap sequence, then checks that the trap vector is taken, the cycle count is unchanged and no second sequence follows. In the wait phase, the bench first sends an IRQ that the masked CC still blocks, then a non-maskable wake-up, to show that only an enabled request ends the wait.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int STEP_W = 4;

  localparam int CC_I = 4;
  localparam int CC_F = 6;
  localparam int CC_E = 7;

  // frame position of each byte, in push order; pulls walk it backwards
  localparam logic [STEP_W-1:0] ST_PCL = 4'd0;
  localparam logic [STEP_W-1:0] ST_PCH = 4'd1;
  localparam logic [STEP_W-1:0] ST_UL  = 4'd2;
  localparam logic [STEP_W-1:0] ST_A   = 4'd10;
  localparam logic [STEP_W-1:0] ST_CC  = 4'd11;

  typedef enum logic [2:0] {
    K_SWI, K_SWI2, K_SWI3, K_IRQ, K_FIRQ, K_NMI, K_CWAI, K_RTI
  } seqKind_t;

  typedef struct packed {
    logic                capture;
    logic                capRti;
    logic                push;
    logic                pull;
    logic                vecHi;
    logic                vecLo;
    logic                fullSet;
    logic [STEP_W-1:0]   step;
    seqKind_t            kind;
  } seqStrobe_t;

  // slot index below the top vector word: address = top - 2*index
  function automatic logic [2:0] vecIndex(seqKind_t k);
    case (k)
      K_NMI:   return 3'd1;
      K_SWI:   return 3'd2;
      K_IRQ:   return 3'd3;
      K_FIRQ:  return 3'd4;
      K_SWI2:  return 3'd5;
      K_SWI3:  return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] entryMask(seqKind_t k);
    logic [BYTE_W-1:0] m;
    m = '0;
    case (k)
      K_SWI, K_FIRQ, K_NMI: begin m[CC_I] = 1'b1; m[CC_F] = 1'b1; end
      K_IRQ:                m[CC_I] = 1'b1;
      default:              m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        nmiReq,
  input  logic        firqReq,
  input  logic        irqReq,
  input  logic        swiReq,
  input  logic [1:0]  swiSel,
  input  logic        cwaiReq,
  input  logic        rtiReq,
  input  logic        irqMaskNow,
  input  logic        firqMaskNow,
  input  logic        irqMaskWait,
  input  logic        firqMaskWait,
  input  logic        pulledE,
  output seqStrobe_t  strb,
  output logic        busy,
  output logic        done
);
  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_WAIT, S_VHI, S_VLO, S_PULL} state_t;

  state_t            state;
  logic [STEP_W-1:0] step;
  seqKind_t          kind;
  logic              full;

  seqKind_t newKind, wakeKind;
  logic     startEntry, startRti, wake;

  always_comb begin
    newKind    = K_SWI;
    startEntry = 1'b0;
    startRti   = 1'b0;
    if (nmiReq) begin
      newKind = K_NMI;  startEntry = 1'b1;
    end else if (firqReq && !firqMaskNow) begin
      newKind = K_FIRQ; startEntry = 1'b1;
    end else if (irqReq && !irqMaskNow) begin
      newKind = K_IRQ;  startEntry = 1'b1;
    end else if (swiReq && swiSel != 2'd3) begin
      newKind    = (swiSel == 2'd0) ? K_SWI : (swiSel == 2'd1) ? K_SWI2 : K_SWI3;
      startEntry = 1'b1;
    end else if (cwaiReq) begin
      newKind = K_CWAI; startEntry = 1'b1;
    end else if (rtiReq) begin
      newKind = K_RTI;  startRti = 1'b1;
    end
  end

  always_comb begin
    wakeKind = K_NMI;
    wake     = 1'b1;
    if (nmiReq)                         wakeKind = K_NMI;
    else if (firqReq && !firqMaskWait)  wakeKind = K_FIRQ;
    else if (irqReq && !irqMaskWait)    wakeKind = K_IRQ;
    else                                wake     = 1'b0;
  end

  always_comb begin
    strb.capture = (state == S_IDLE) && startEntry;
    strb.capRti  = (state == S_IDLE) && startRti;
    strb.push    = (state == S_PUSH);
    strb.pull    = (state == S_PULL);
    strb.vecHi   = (state == S_VHI);
    strb.vecLo   = (state == S_VLO);
    strb.fullSet = (newKind != K_FIRQ);
    strb.step    = step;
    if (state == S_IDLE)             strb.kind = newKind;
    else if (state == S_WAIT && wake) strb.kind = wakeKind;
    else                              strb.kind = kind;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= '0;
      kind  <= K_SWI;
      full  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (startEntry) begin
            state <= S_PUSH;
            step  <= ST_PCL;
            kind  <= newKind;
            full  <= (newKind != K_FIRQ);
          end else if (startRti) begin
            state <= S_PULL;
            step  <= ST_CC;
            kind  <= K_RTI;
          end
        end
        S_PUSH: begin
          if (step == ST_CC)
            state <= (kind == K_CWAI) ? S_WAIT : S_VHI;
          else if (step == ST_PCH && !full)
            step <= ST_CC;
          else
            step <= step + 1'b1;
        end
        S_WAIT: begin
          if (wake) begin
            kind  <= wakeKind;
            state <= S_VHI;
          end
        end
        S_VHI: state <= S_VLO;
        S_VLO: state <= S_IDLE;
        S_PULL: begin
          if (step == ST_PCL)     state <= S_IDLE;
          else if (step == ST_CC) step  <= pulledE ? ST_A : ST_PCH;
          else                    step  <= step - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_VLO) || (state == S_PULL && step == ST_PCL);

  // R6: the sequence releases the block right after its final cycle
  p_done_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
endmodule

// File: rtl/stk_seq_dp.sv
module stk_seq_dp
  import stk_seq_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_TOP = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [BYTE_W-1:0] cwaiMask,
  input  logic [WORD_W-1:0] pcIn,
  input  logic [WORD_W-1:0] uIn,
  input  logic [WORD_W-1:0] yIn,
  input  logic [WORD_W-1:0] xIn,
  input  logic [WORD_W-1:0] sIn,
  input  logic [BYTE_W-1:0] dpIn,
  input  logic [BYTE_W-1:0] aIn,
  input  logic [BYTE_W-1:0] bIn,
  input  logic [BYTE_W-1:0] ccIn,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic              memWr,
  output logic              memRd,
  output logic [BYTE_W-1:0] memWdata,
  output logic              pcLoad,
  output logic [WORD_W-1:0] pcOut,
  output logic              ccLoad,
  output logic [BYTE_W-1:0] ccOut,
  output logic              sLoad,
  output logic [WORD_W-1:0] sOut,
  output logic              laneWe,
  output logic [STEP_W-1:0] laneSel,
  output logic [BYTE_W-1:0] laneData,
  output logic [BYTE_W-1:0] ccWork
);
  logic [WORD_W-1:0] sPtr;
  logic [BYTE_W-1:0] hiLatch;
  logic [BYTE_W-1:0] ccBase;
  logic [WORD_W-1:0] vecAddr;
  logic              pullPcHi, pullPcLo;

  assign ccBase   = (strb.kind == K_CWAI) ? (ccIn & cwaiMask) : ccIn;
  assign vecAddr  = VEC_TOP - {{(WORD_W-4){1'b0}}, vecIndex(strb.kind), 1'b0};
  assign pullPcHi = strb.pull && strb.step == ST_PCH;
  assign pullPcLo = strb.pull && strb.step == ST_PCL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sPtr    <= '0;
      ccWork  <= '0;
      hiLatch <= '0;
    end else begin
      if (strb.capture) begin
        sPtr   <= sIn;
        ccWork <= strb.fullSet ? (ccBase | (BYTE_W'(1) << CC_E))
                               : (ccBase & ~(BYTE_W'(1) << CC_E));
      end else if (strb.capRti) begin
        sPtr <= sIn;
      end else if (strb.push) begin
        sPtr <= sPtr - 1'b1;
      end else if (strb.pull) begin
        sPtr <= sPtr + 1'b1;
      end
      if (strb.vecHi || pullPcHi) hiLatch <= memRdata;
    end
  end

  always_comb begin
    case (strb.step)
      4'd0:    memWdata = pcIn[7:0];
      4'd1:    memWdata = pcIn[15:8];
      4'd2:    memWdata = uIn[7:0];
      4'd3:    memWdata = uIn[15:8];
      4'd4:    memWdata = yIn[7:0];
      4'd5:    memWdata = yIn[15:8];
      4'd6:    memWdata = xIn[7:0];
      4'd7:    memWdata = xIn[15:8];
      4'd8:    memWdata = dpIn;
      4'd9:    memWdata = bIn;
      4'd10:   memWdata = aIn;
      default: memWdata = ccWork;
    endcase
  end

  always_comb begin
    if (strb.push)       memAddr = sPtr - 1'b1;
    else if (strb.pull)  memAddr = sPtr;
    else if (strb.vecHi) memAddr = vecAddr;
    else if (strb.vecLo) memAddr = vecAddr + 1'b1;
    else                 memAddr = '0;
  end

  assign memWr    = strb.push;
  assign memRd    = strb.pull || strb.vecHi || strb.vecLo;
  assign pcLoad   = strb.vecLo || pullPcLo;
  assign pcOut    = {hiLatch, memRdata};
  assign ccLoad   = strb.vecLo || (strb.pull && strb.step == ST_CC);
  assign ccOut    = strb.vecLo ? (ccWork | entryMask(strb.kind)) : memRdata;
  assign sLoad    = strb.vecLo || pullPcLo;
  assign sOut     = pullPcLo ? sPtr + 1'b1 : sPtr;
  assign laneWe   = strb.pull && strb.step >= ST_UL && strb.step <= ST_A;
  assign laneSel  = strb.step;
  assign laneData = memRdata;

  // R2: consecutive pushes walk the stack downward by one byte
  p_push_descend_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && $past(strb.push)) |-> memAddr == $past(memAddr) - 1'b1);
  // R8: consecutive pulls walk the stack upward by one byte
  p_pull_ascend_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pull && $past(strb.pull)) |-> memAddr == $past(memAddr) + 1'b1);
  // R4: vector low byte is read right after the high byte, one address above
  p_vec_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.vecLo |-> ($past(strb.vecHi) && memAddr == $past(memAddr) + 1'b1));
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import stk_seq_pkg::*;
#(
  parameter logic [15:0] VEC_TOP = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        nmiReq,
  input  logic        firqReq,
  input  logic        irqReq,
  input  logic        swiReq,
  input  logic [1:0]  swiSel,
  input  logic        cwaiReq,
  input  logic [7:0]  cwaiMask,
  input  logic        rtiReq,
  input  logic [15:0] pcIn,
  input  logic [15:0] uIn,
  input  logic [15:0] yIn,
  input  logic [15:0] xIn,
  input  logic [15:0] sIn,
  input  logic [7:0]  dpIn,
  input  logic [7:0]  aIn,
  input  logic [7:0]  bIn,
  input  logic [7:0]  ccIn,
  output logic [15:0] memAddr,
  output logic        memWr,
  output logic        memRd,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  output logic        pcLoad,
  output logic [15:0] pcOut,
  output logic        ccLoad,
  output logic [7:0]  ccOut,
  output logic        sLoad,
  output logic [15:0] sOut,
  output logic        laneWe,
  output logic [3:0]  laneSel,
  output logic [7:0]  laneData,
  output logic        busy,
  output logic        done
);
  seqStrobe_t        strb;
  logic [BYTE_W-1:0] ccWork;

  stk_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .nmiReq       (nmiReq),
    .firqReq      (firqReq),
    .irqReq       (irqReq),
    .swiReq       (swiReq),
    .swiSel       (swiSel),
    .cwaiReq      (cwaiReq),
    .rtiReq       (rtiReq),
    .irqMaskNow   (ccIn[CC_I]),
    .firqMaskNow  (ccIn[CC_F]),
    .irqMaskWait  (ccWork[CC_I]),
    .firqMaskWait (ccWork[CC_F]),
    .pulledE      (memRdata[CC_E]),
    .strb         (strb),
    .busy         (busy),
    .done         (done)
  );

  stk_seq_dp #(.VEC_TOP(VEC_TOP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cwaiMask (cwaiMask),
    .pcIn     (pcIn),
    .uIn      (uIn),
    .yIn      (yIn),
    .xIn      (xIn),
    .sIn      (sIn),
    .dpIn     (dpIn),
    .aIn      (aIn),
    .bIn      (bIn),
    .ccIn     (ccIn),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWr    (memWr),
    .memRd    (memRd),
    .memWdata (memWdata),
    .pcLoad   (pcLoad),
    .pcOut    (pcOut),
    .ccLoad   (ccLoad),
    .ccOut    (ccOut),
    .sLoad    (sLoad),
    .sOut     (sOut),
    .laneWe   (laneWe),
    .laneSel  (laneSel),
    .laneData (laneData),
    .ccWork   (ccWork)
  );

  // R4: the memory port never reads and writes in the same cycle
  p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  // R11: memory is only touched inside a running sequence
  p_mem_in_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memWr || memRd) |-> busy);
  // R6: final stack pointer and PC are loaded together with done
  p_done_loads_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sLoad && pcLoad));
endmodule

// File: tb/sim_irq_stack_seq.sv
module sim_irq_stack_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [5:0]  reqV = '0;  // 0 nmi, 1 firq, 2 irq, 3 swi, 4 cwai, 5 rti
  logic [1:0]  swiSel = '0;
  logic [7:0]  cwaiMask = 8'hFF;
  logic [15:0] pcR, uR, yR, xR, sR;
  logic [7:0]  dpR, aR, bR, ccR;
  logic [15:0] memAddr, pcOut, sOut;
  logic        memWr, memRd, pcLoad, ccLoad, sLoad, laneWe, busy, done;
  logic [7:0]  memWdata, memRdata, ccOut, laneData;
  logic [3:0]  laneSel;
  logic [7:0]  mem [0:255];

  logic        tbLoad = 1'b0, tbWe = 1'b0;
  logic [7:0]  tbAddr = '0, tbData = '0;
  logic [15:0] tPc, tU, tY, tX, tS;
  logic [7:0]  tDp, tA, tB, tCc;

  int total = 0, fails = 0;

  irq_stack_seq u0 (
    .clk(clk), .rstN(rstN),
    .nmiReq(reqV[0]), .firqReq(reqV[1]), .irqReq(reqV[2]), .swiReq(reqV[3]),
    .swiSel(swiSel), .cwaiReq(reqV[4]), .cwaiMask(cwaiMask), .rtiReq(reqV[5]),
    .pcIn(pcR), .uIn(uR), .yIn(yR), .xIn(xR), .sIn(sR),
    .dpIn(dpR), .aIn(aR), .bIn(bR), .ccIn(ccR),
    .memAddr(memAddr), .memWr(memWr), .memRd(memRd), .memWdata(memWdata),
    .memRdata(memRdata),
    .pcLoad(pcLoad), .pcOut(pcOut), .ccLoad(ccLoad), .ccOut(ccOut),
    .sLoad(sLoad), .sOut(sOut), .laneWe(laneWe), .laneSel(laneSel),
    .laneData(laneData), .busy(busy), .done(done)
  );

  assign memRdata = mem[memAddr[7:0]];

  always_ff @(posedge clk) begin
    if (tbLoad) begin
      pcR <= tPc; uR <= tU; yR <= tY; xR <= tX; sR <= tS;
      dpR <= tDp; aR <= tA; bR <= tB; ccR <= tCc;
    end else begin
      if (pcLoad) pcR <= pcOut;
      if (ccLoad) ccR <= ccOut;
      if (sLoad)  sR  <= sOut;
      if (laneWe) begin
        case (laneSel)
          4'd2:  uR[7:0]  <= laneData;
          4'd3:  uR[15:8] <= laneData;
          4'd4:  yR[7:0]  <= laneData;
          4'd5:  yR[15:8] <= laneData;
          4'd6:  xR[7:0]  <= laneData;
          4'd7:  xR[15:8] <= laneData;
          4'd8:  dpR      <= laneData;
          4'd9:  bR       <= laneData;
          4'd10: aR       <= laneData;
          default: ;
        endcase
      end
    end
    if (memWr) mem[memAddr[7:0]] <= memWdata;
    else if (tbWe) mem[tbAddr] <= tbData;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setRegs(input logic [7:0] cc, input logic [15:0] s);
    @(negedge clk);
    tPc = 16'h1234; tU = 16'h5678; tY = 16'h9ABC; tX = 16'hDEF0; tS = s;
    tDp = 8'h21; tA = 8'h43; tB = 8'h65; tCc = cc;
    tbLoad = 1'b1;
    @(negedge clk);
    tbLoad = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tbAddr = a; tbData = d; tbWe = 1'b1;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic waitDone(output int len);
    len = 1;
    while (!done && len < 100) begin
      len++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  // pulse requests r; at busy cycle injAt pulse NMI and return together
  task automatic go(input logic [5:0] r, input int injAt, output int len);
    @(negedge clk) reqV = r;
    @(negedge clk) reqV = '0;
    len = 1;
    while (!done && len < 100) begin
      reqV = (len == injAt) ? 6'b100001 : 6'b000000;
      len++;
      @(negedge clk);
    end
    reqV = '0;
    @(negedge clk);
  endtask

  function automatic logic [15:0] vecPc(input logic [7:0] lo);
    return {8'hC0 ^ lo, lo};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired, run hung");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int len;
    logic [7:0] vlo, ccSt, ccFin, cc0;
    logic [5:0] r;
    logic full;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int v = 8'hF2; v <= 8'hFD; v += 2) begin
      mem[v]   = 8'hC0 ^ 8'(v + 1);
      mem[v+1] = 8'(v + 1);
    end
    // vector slots: hi at F2+2k holds C0^lo, lo = slot+1 address low byte
    tPc = '0; tU = '0; tY = '0; tX = '0; tS = '0;
    tDp = '0; tA = '0; tB = '0; tCc = '0;
    tbLoad = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {15'd0, busy}, 16'd0);
    chk("R1 strobes in reset", {10'd0, memWr, memRd, pcLoad, ccLoad, sLoad, laneWe}, 16'd0);
    rstN = 1'b1;
    tbLoad = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {14'd0, busy, done}, 16'd0);

    // sweep of every entry kind under two CC patterns
    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < 2; c++) begin
        cc0 = (c == 0) ? 8'h00 : 8'h2F;
        setRegs(cc0, 16'h0040);
        swiSel = 2'd0;
        case (k)
          0: begin r = 6'b001000; vlo = 8'hFB; ccFin = 8'h50; end
          1: begin r = 6'b001000; swiSel = 2'd1; vlo = 8'hF5; ccFin = 8'h00; end
          2: begin r = 6'b001000; swiSel = 2'd2; vlo = 8'hF3; ccFin = 8'h00; end
          3: begin r = 6'b000100; vlo = 8'hF9; ccFin = 8'h10; end
          4: begin r = 6'b000010; vlo = 8'hF7; ccFin = 8'h50; end
          default: begin r = 6'b000001; vlo = 8'hFD; ccFin = 8'h50; end
        endcase
        full = (k != 4);
        ccSt = full ? (cc0 | 8'h80) : (cc0 & 8'h7F);
        ccFin = ccFin | ccSt;
        go(r, -1, len);
        chk($sformatf("R12 R4 vector pc kind%0d", k), pcR, vecPc(vlo));
        chk($sformatf("R5 final cc kind%0d", k), {8'd0, ccR}, {8'd0, ccFin});
        chk("R2 stacked pc low", {8'd0, mem[8'h3F]}, 16'h0034);
        chk("R2 stacked pc high", {8'd0, mem[8'h3E]}, 16'h0012);
        if (full) begin
          chk("R4 full busy length", 16'(len), 16'd14);
          chk("R2 stacked U high", {8'd0, mem[8'h3C]}, 16'h0056);
          chk("R2 stacked X low", {8'd0, mem[8'h39]}, 16'h00F0);
          chk("R2 stacked DP", {8'd0, mem[8'h37]}, 16'h0021);
          chk("R2 stacked B", {8'd0, mem[8'h36]}, 16'h0065);
          chk("R2 stacked A", {8'd0, mem[8'h35]}, 16'h0043);
          chk("R2 stacked cc with E", {8'd0, mem[8'h34]}, {8'd0, ccSt});
          chk("R6 final S full", sR, 16'h0034);
        end else begin
          chk("R3 firq busy length", 16'(len), 16'd5);
          chk("R3 firq stacked cc", {8'd0, mem[8'h3D]}, {8'd0, ccSt});
          chk("R3 R6 final S short", sR, 16'h003D);
        end
        chk("R6 released", {15'd0, busy}, 16'd0);
      end
    end

    // masking in idle
    setRegs(8'h10, 16'h0040);
    @(negedge clk) reqV = 6'b000100;
    @(negedge clk) reqV = '0;
    chk("R10 masked irq ignored", {14'd0, busy, memWr}, 16'd0);
    @(negedge clk);
    chk("R10 masked irq pc kept", pcR, 16'h1234);
    setRegs(8'h40, 16'h0040);
    @(negedge clk) reqV = 6'b000010;
    @(negedge clk) reqV = '0;
    chk("R10 masked firq ignored", {15'd0, busy}, 16'd0);
    setRegs(8'h50, 16'h0040);
    go(6'b000001, -1, len);
    chk("R10 nmi unmaskable", pcR, vecPc(8'hFD));
    setRegs(8'h00, 16'h0040);
    swiSel = 2'd3;
    @(negedge clk) reqV = 6'b001000;
    @(negedge clk) reqV = '0;
    chk("R12 selector 3 rejected", {15'd0, busy}, 16'd0);
    swiSel = 2'd0;

    // same-cycle priority
    setRegs(8'h00, 16'h0040);
    go(6'b001001, -1, len);
    chk("R9 nmi over swi", pcR, vecPc(8'hFD));
    setRegs(8'h00, 16'h0040);
    go(6'b000110, -1, len);
    chk("R9 firq over irq pc", pcR, vecPc(8'hF7));
    chk("R9 firq over irq length", 16'(len), 16'd5);
    setRegs(8'h00, 16'h0040);
    go(6'b111100, -1, len);
    chk("R9 irq over swi cwai rti", pcR, vecPc(8'hF9));

    // requests during a running sequence
    setRegs(8'h00, 16'h0040);
    go(6'b001000, 3, len);
    chk("R11 swi length unchanged", 16'(len), 16'd14);
    chk("R11 swi vector kept", pcR, vecPc(8'hFB));
    repeat (2) @(negedge clk);
    chk("R11 no follow-on sequence", {15'd0, busy}, 16'd0);

    // mask-and-wait: masks cleared, then irq wakes
    setRegs(8'h50, 16'h0040);
    cwaiMask = 8'hAF;
    @(negedge clk) reqV = 6'b010000;
    @(negedge clk) reqV = '0;
    repeat (15) @(negedge clk);
    chk("R7 waiting busy quiet", {14'd0, busy, memWr}, 16'h0002);
    chk("R7 stacked masked cc", {8'd0, mem[8'h34]}, 16'h0080);
    reqV = 6'b000100;
    @(negedge clk) reqV = '0;
    waitDone(len);
    chk("R7 irq wake vector", pcR, vecPc(8'hF9));
    chk("R7 irq wake cc", {8'd0, ccR}, 16'h0090);
    chk("R7 wait final S", sR, 16'h0034);

    // mask-and-wait keeping I: irq blocked, nmi wakes
    setRegs(8'h10, 16'h0040);
    cwaiMask = 8'hFF;
    @(negedge clk) reqV = 6'b010000;
    @(negedge clk) reqV = '0;
    repeat (14) @(negedge clk);
    reqV = 6'b000100;
    @(negedge clk) reqV = '0;
    repeat (3) @(negedge clk);
    chk("R7 masked irq does not wake", {14'd0, busy, memRd}, 16'h0002);
    reqV = 6'b000001;
    @(negedge clk) reqV = '0;
    waitDone(len);
    chk("R7 nmi wake vector", pcR, vecPc(8'hFD));
    chk("R7 nmi wake cc", {8'd0, ccR}, 16'h00D0);

    // return, full frame
    poke(8'h60, 8'h8B); poke(8'h61, 8'h11); poke(8'h62, 8'h22);
    poke(8'h63, 8'h33); poke(8'h64, 8'h44); poke(8'h65, 8'h55);
    poke(8'h66, 8'h66); poke(8'h67, 8'h77); poke(8'h68, 8'h88);
    poke(8'h69, 8'h99); poke(8'h6A, 8'hAA); poke(8'h6B, 8'hBB);
    setRegs(8'h00, 16'h0060);
    go(6'b100000, -1, len);
    chk("R8 full return length", 16'(len), 16'd12);
    chk("R8 cc pulled", {8'd0, ccR}, 16'h008B);
    chk("R8 A pulled", {8'd0, aR}, 16'h0011);
    chk("R8 B pulled", {8'd0, bR}, 16'h0022);
    chk("R8 DP pulled", {8'd0, dpR}, 16'h0033);
    chk("R8 X pulled", xR, 16'h4455);
    chk("R8 Y pulled", yR, 16'h6677);
    chk("R8 U pulled", uR, 16'h8899);
    chk("R8 pc pulled", pcR, 16'hAABB);
    chk("R8 R6 S after full", sR, 16'h006C);

    // return, short frame
    poke(8'h70, 8'h05); poke(8'h71, 8'h3C); poke(8'h72, 8'h4D);
    setRegs(8'h00, 16'h0070);
    go(6'b100000, -1, len);
    chk("R8 short return length", 16'(len), 16'd3);
    chk("R8 short cc", {8'd0, ccR}, 16'h0005);
    chk("R8 short pc", pcR, 16'h3C4D);
    chk("R8 short S", sR, 16'h0073);
    chk("R8 short leaves A", {8'd0, aR}, 16'h0043);
    chk("R8 short leaves X", xR, 16'hDEF0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule